// File: doc/BRIEF.md
# Partitionable dual-channel DMA FIFO

This block holds a single 16-entry, 32-bit data store and divides it between two disk-interface channels. A small configuration selects how the entries are shared: an even half each, everything to channel 0, or everything to channel 1. Each channel behaves as its own circular buffer within its share. It has its own write and read strobes, full and empty flags, and a 2-bit fill threshold. When the threshold is reached, the channel raises its DMA request toward the bus-master engine.

A request is also raised when a flush condition is seen while data remains in the channel. There are three such conditions: an explicit flush strobe, an interrupt from a read transfer (when enabled), and the end of a 128-word sector (when enabled). A channel whose share is zero reports that DMA is not allowed, ignores writes and never requests.

The configuration comes either from explicit codes or from a default derived from which channels are enabled. A new configuration takes effect only while both channels are empty. Applying it clears both channels' pointers, counts and sector counters.

Top module: `dfifo_top`

## Requirements
- R1: Split code split_i (when cfg_sel_i=1) maps 2'b00 to 16 entries for channel 0 and none for channel 1, 2'b11 to 16 entries for channel 1 and none for channel 0, and 2'b01 or 2'b10 to 8 entries each; dma_ok_o[c] is 1 exactly when channel c has a non-zero share.
- R2: With threshold code t for channel c, req_o[c] is 1 whenever the channel's word count is at least S for t=2'b00, S-S/4 for t=2'b01, S/2 for t=2'b10 and S/4 for t=2'b11, where S is the channel's share.
- R3: A channel with zero share keeps dma_ok_o low, req_o low and empty_o high, and writes to it are dropped.
- R4: With cfg_sel_i=0, chan_en_i=2'b01 selects all 16 entries for channel 0 with threshold code 2'b01, chan_en_i=2'b10 selects all 16 for channel 1 with code 2'b01, and any other value selects the even split with code 2'b01 on both channels.
- R5: Out of reset every channel is empty with no request; full_o[c] is set when the count equals the channel's share, writes while full and reads while empty are dropped.
- R6: A pulse on flush_i[c] while channel c holds data raises req_o[c] from the next cycle until the channel drains to empty, after which the request falls.
- R7: A pulse on irq_i[c] acts as a flush only while irq_flush_en_i[c] is 1; otherwise it leaves req_o[c] unchanged.
- R8: With eos_flush_en_i[c]=1, the 128th accepted write since the channel was last cleared acts as a flush for that channel (and likewise every 128 writes after that).
- R9: A configuration change is held off while either channel holds data, and it is applied only once both are empty; applying it clears both channels.
- R10: Each channel returns its words in write order on rdata_o[c] (the word at the head before a read strobe), independently of the other channel; a write and a read in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sel_i | input | 1 | 1: use split_i/thr codes, 0: default from chan_en_i |
| chan_en_i | input | 2 | Channel enable per channel (default selection) |
| split_i | input | 2 | Explicit split code |
| thr0_i | input | 2 | Channel 0 threshold code |
| thr1_i | input | 2 | Channel 1 threshold code |
| irq_flush_en_i | input | 2 | Per-channel enable of flush on read interrupt |
| eos_flush_en_i | input | 2 | Per-channel enable of flush at sector end |
| wr_i | input | 2 | Per-channel write strobe |
| wdata_i | input | 2x32 | Per-channel write data |
| rd_i | input | 2 | Per-channel read strobe |
| rdata_o | output | 2x32 | Per-channel head word |
| flush_i | input | 2 | Per-channel explicit flush |
| irq_i | input | 2 | Per-channel read-transfer interrupt |
| req_o | output | 2 | Per-channel DMA request |
| dma_ok_o | output | 2 | Per-channel DMA allowed |
| full_o | output | 2 | Per-channel full flag |
| empty_o | output | 2 | Per-channel empty flag |

## Verification
A write and a read can fall on one channel in the same cycle. The bench provokes this after loading a word and then checks that the count and flags do not move and that the words still come out in order. A flush and the draining read can also coincide. Here the bench flushes a single word, reads it out, and then checks that the request falls and that the pending flush does not return on the next write. A configuration change that arrives while data is present is judged by dma_ok_o, which must keep its old value until the last word has been read.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef struct packed {
    logic [1:0] split;
    logic [1:0] thr0;
    logic [1:0] thr1;
  } cfg_t;

  localparam logic [1:0] THR_DEFAULT = 2'b01;
  localparam logic [1:0] SPLIT_EVEN  = 2'b01;
endpackage

// File: rtl/dfifo_cfg.sv
module dfifo_cfg
  import dfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_sel_i,
  input  logic [1:0]           chan_en_i,
  input  logic [1:0]           split_i,
  input  logic [1:0]           thr0_i,
  input  logic [1:0]           thr1_i,
  input  logic                 all_empty_i,
  output logic                 clr_o,
  output logic [1:0][1:0]      thr_o,
  output logic [1:0][AW:0]     size_o,
  output logic [1:0][AW-1:0]   base_o
);
  localparam logic [AW:0]   FULL_SZ = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF_SZ = (AW+1)'(DEPTH / 2);

  cfg_t cand, cur_q;

  always_comb begin
    if (cfg_sel_i) begin
      cand = '{split: split_i, thr0: thr0_i, thr1: thr1_i};
    end else begin
      unique case (chan_en_i)
        2'b01:   cand = '{split: 2'b00, thr0: THR_DEFAULT, thr1: THR_DEFAULT};
        2'b10:   cand = '{split: 2'b11, thr0: THR_DEFAULT, thr1: THR_DEFAULT};
        default: cand = '{split: SPLIT_EVEN, thr0: THR_DEFAULT, thr1: THR_DEFAULT};
      endcase
    end
  end

  assign clr_o = (cand != cur_q) && all_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '{split: SPLIT_EVEN, thr0: THR_DEFAULT, thr1: THR_DEFAULT};
    else if (clr_o) cur_q <= cand;
  end

  always_comb begin
    base_o[0] = '0;
    unique case (cur_q.split)
      2'b00: begin size_o[0] = FULL_SZ; size_o[1] = '0;      base_o[1] = '0; end
      2'b11: begin size_o[0] = '0;      size_o[1] = FULL_SZ; base_o[1] = '0; end
      default: begin
        size_o[0] = HALF_SZ;
        size_o[1] = HALF_SZ;
        base_o[1] = AW'(DEPTH / 2);
      end
    endcase
    thr_o[0] = cur_q.thr0;
    thr_o[1] = cur_q.thr1;
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_empty_i |=> $stable(cur_q));
endmodule

// File: rtl/dfifo_chan.sv
module dfifo_chan #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned SECT_WORDS = 128,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned SW        = $clog2(SECT_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW:0]   size_i,
  input  logic [1:0]    thr_code_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          flush_i,
  input  logic          irq_i,
  input  logic          irq_en_i,
  input  logic          eos_en_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic          wr_ok_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          req_o,
  output logic          dma_ok_o
);
  logic [AW:0]   cnt_q, cnt_d, thr_lvl;
  logic [AW-1:0] wp_q, rp_q;
  logic [SW-1:0] sec_q;
  logic          pend_q, pend_d, rd_ok, eos, flush_ev;

  assign dma_ok_o = (size_i != '0);
  assign full_o   = dma_ok_o && (cnt_q == size_i);
  assign empty_o  = (cnt_q == '0);
  assign wr_ok_o  = wr_i && dma_ok_o && !full_o && !clr_i;
  assign rd_ok    = rd_i && !empty_o && !clr_i;
  assign wptr_o   = wp_q;
  assign rptr_o   = rp_q;

  always_comb begin
    unique case (thr_code_i)
      2'b00:   thr_lvl = size_i;
      2'b01:   thr_lvl = size_i - (size_i >> 2);
      2'b10:   thr_lvl = size_i >> 1;
      default: thr_lvl = size_i >> 2;
    endcase
  end

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p, logic [AW:0] lim);
    return (({1'b0, p} + 1'b1) == lim) ? '0 : p + 1'b1;
  endfunction

  assign eos      = wr_ok_o && (sec_q == SW'(SECT_WORDS - 1));
  assign flush_ev = flush_i || (irq_i && irq_en_i) || (eos && eos_en_i);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok_o && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok_o) cnt_d = cnt_q - 1'b1;
    pend_d = (pend_q || flush_ev) && (cnt_d != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; wp_q <= '0; rp_q <= '0; sec_q <= '0; pend_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; wp_q <= '0; rp_q <= '0; sec_q <= '0; pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      if (wr_ok_o) begin
        wp_q  <= bump(wp_q, size_i);
        sec_q <= sec_q + 1'b1;
      end
      if (rd_ok) rp_q <= bump(rp_q, size_i);
    end
  end

  assign req_o = dma_ok_o && !empty_o && ((cnt_q >= thr_lvl) || pend_q);

  // R3
  no_req_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_ok_o |-> !req_o && empty_o);
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= size_i);
  // R2
  thr_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o && !rd_ok && (cnt_q + 1'b1 == thr_lvl)) ##1 !clr_i |-> req_o);
  // R6
  empty_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !req_o);
endmodule

// File: rtl/dfifo_top.sv
module dfifo_top
  import dfifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned DW         = 32,
  parameter int unsigned SECT_WORDS = 128,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned NCH       = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_sel_i,
  input  logic [NCH-1:0]         chan_en_i,
  input  logic [1:0]             split_i,
  input  logic [1:0]             thr0_i,
  input  logic [1:0]             thr1_i,
  input  logic [NCH-1:0]         irq_flush_en_i,
  input  logic [NCH-1:0]         eos_flush_en_i,
  input  logic [NCH-1:0]         wr_i,
  input  logic [NCH-1:0][DW-1:0] wdata_i,
  input  logic [NCH-1:0]         rd_i,
  output logic [NCH-1:0][DW-1:0] rdata_o,
  input  logic [NCH-1:0]         flush_i,
  input  logic [NCH-1:0]         irq_i,
  output logic [NCH-1:0]         req_o,
  output logic [NCH-1:0]         dma_ok_o,
  output logic [NCH-1:0]         full_o,
  output logic [NCH-1:0]         empty_o
);
  logic                   clr;
  logic [NCH-1:0][1:0]    thr;
  logic [NCH-1:0][AW:0]   size;
  logic [NCH-1:0][AW-1:0] base, wptr, rptr, waddr, raddr;
  logic [NCH-1:0]         wr_ok;
  logic [DW-1:0]          mem_q [DEPTH];

  dfifo_cfg #(.DEPTH(DEPTH)) i_cfg (
    .clk_i, .rst_ni, .cfg_sel_i, .chan_en_i, .split_i, .thr0_i, .thr1_i,
    .all_empty_i(&empty_o), .clr_o(clr), .thr_o(thr), .size_o(size), .base_o(base)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dfifo_chan #(.DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS)) i_chan (
      .clk_i, .rst_ni, .clr_i(clr), .size_i(size[c]), .thr_code_i(thr[c]),
      .wr_i(wr_i[c]), .rd_i(rd_i[c]), .flush_i(flush_i[c]), .irq_i(irq_i[c]),
      .irq_en_i(irq_flush_en_i[c]), .eos_en_i(eos_flush_en_i[c]),
      .wptr_o(wptr[c]), .rptr_o(rptr[c]), .wr_ok_o(wr_ok[c]),
      .full_o(full_o[c]), .empty_o(empty_o[c]), .req_o(req_o[c]), .dma_ok_o(dma_ok_o[c])
    );
    assign waddr[c]   = base[c] + wptr[c];
    assign raddr[c]   = base[c] + rptr[c];
    assign rdata_o[c] = mem_q[raddr[c]];
  end

  always_ff @(posedge clk_i) begin
    for (int c = 0; c < NCH; c++) begin
      if (wr_ok[c]) mem_q[waddr[c]] <= wdata_i[c];
    end
  end

  // R1
  no_addr_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wr_ok) |-> (waddr[0] != waddr[1]));
endmodule

// File: tb/test_dfifo_top.sv
module test_dfifo_top;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_sel_i = 1'b1;
  logic [1:0]       chan_en_i = 2'b11;
  logic [1:0]       split_i = 2'b01;
  logic [1:0]       thr0_i = 2'b10;
  logic [1:0]       thr1_i = 2'b11;
  logic [1:0]       irq_flush_en_i = 2'b00;
  logic [1:0]       eos_flush_en_i = 2'b00;
  logic [1:0]       wr_i = '0, rd_i = '0, flush_i = '0, irq_i = '0;
  logic [1:0][31:0] wdata_i = '0;
  logic [1:0][31:0] rdata_o;
  logic [1:0]       req_o, dma_ok_o, full_o, empty_o;

  int n_chk = 0, n_fail = 0;
  int mcnt[2] = '{0, 0};
  int msz[2]  = '{8, 8};
  logic [31:0] q0[$], q1[$];

  always #4 clk_i = ~clk_i;

  dfifo_top i_dfifo_top (.*);

  task automatic tick; @(posedge clk_i); #2; endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(int ch, logic [31:0] d);
    bit acc = (mcnt[ch] < msz[ch]);
    wr_i[ch] = 1'b1; wdata_i[ch] = d;
    tick;
    wr_i[ch] = 1'b0;
    if (acc) begin
      if (ch == 0) q0.push_back(d); else q1.push_back(d);
      mcnt[ch]++;
    end
  endtask

  task automatic take(int ch);
    logic [31:0] e;
    if (mcnt[ch] > 0) begin
      e = (ch == 0) ? q0[0] : q1[0];
      chk(rdata_o[ch] == e, "R10 data order", int'(rdata_o[ch]), int'(e));
    end
    rd_i[ch] = 1'b1;
    tick;
    rd_i[ch] = 1'b0;
    if (mcnt[ch] > 0) begin
      if (ch == 0) void'(q0.pop_front()); else void'(q1.pop_front());
      mcnt[ch]--;
    end
  endtask

  task automatic drain(int ch);
    while (mcnt[ch] > 0) take(ch);
    chk(empty_o[ch] == 1'b1, "R5 empty after drain", int'(empty_o[ch]), 1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #19 rst_ni = 1'b1;
    tick;
    chk(empty_o == 2'b11, "R5 reset empty", int'(empty_o), 3);
    chk(req_o == 2'b00, "R5 reset req", int'(req_o), 0);
    chk(full_o == 2'b00, "R5 reset full", int'(full_o), 0);
    tick;
    chk(dma_ok_o == 2'b11, "R1 even split dma_ok", int'(dma_ok_o), 3);

    // even split, ch0 thr 1/2 of 8 = 4
    for (int i = 0; i < 3; i++) put(0, 32'h100 + i);
    chk(req_o[0] == 1'b0, "R2 below threshold", int'(req_o[0]), 0);
    put(0, 32'h103);
    chk(req_o[0] == 1'b1, "R2 threshold 1/2", int'(req_o[0]), 1);
    for (int i = 4; i < 8; i++) put(0, 32'h100 + i);
    chk(full_o[0] == 1'b1, "R1 ch0 full at 8", int'(full_o[0]), 1);
    put(0, 32'hdead);
    drain(0);
    take(0);
    chk(empty_o[0] == 1'b1, "R5 read while empty", int'(empty_o[0]), 1);

    // ch1 thr 1/4 of 8 = 2
    put(1, 32'h200);
    chk(req_o[1] == 1'b0, "R2 ch1 below", int'(req_o[1]), 0);
    put(1, 32'h201);
    chk(req_o[1] == 1'b1, "R2 threshold 1/4", int'(req_o[1]), 1);
    chk(req_o[0] == 1'b0, "R10 ch0 independent", int'(req_o[0]), 0);
    drain(1);

    // explicit flush
    put(0, 32'h300);
    chk(req_o[0] == 1'b0, "R6 single word no req", int'(req_o[0]), 0);
    flush_i[0] = 1'b1; tick; flush_i[0] = 1'b0;
    chk(req_o[0] == 1'b1, "R6 flush req", int'(req_o[0]), 1);
    take(0);
    chk(req_o[0] == 1'b0, "R6 req falls when drained", int'(req_o[0]), 0);
    put(0, 32'h301);
    chk(req_o[0] == 1'b0, "R6 flush not sticky", int'(req_o[0]), 0);
    drain(0);

    // interrupt flush
    put(1, 32'h400);
    irq_i[1] = 1'b1; tick; irq_i[1] = 1'b0;
    chk(req_o[1] == 1'b0, "R7 irq ignored when disabled", int'(req_o[1]), 0);
    irq_flush_en_i[1] = 1'b1;
    irq_i[1] = 1'b1; tick; irq_i[1] = 1'b0;
    chk(req_o[1] == 1'b1, "R7 irq flush", int'(req_o[1]), 1);
    drain(1);
    irq_flush_en_i[1] = 1'b0;

    // simultaneous write and read
    put(1, 32'h500);
    wr_i[1] = 1'b1; rd_i[1] = 1'b1; wdata_i[1] = 32'h501;
    chk(rdata_o[1] == 32'h500, "R10 head before wr+rd", int'(rdata_o[1]), 32'h500);
    tick;
    wr_i[1] = 1'b0; rd_i[1] = 1'b0;
    void'(q1.pop_front()); q1.push_back(32'h501);
    chk(empty_o[1] == 1'b0 && full_o[1] == 1'b0, "R10 count kept", int'(empty_o[1]), 0);
    put(1, 32'h502);
    chk(req_o[1] == 1'b1, "R10 count two after wr+rd", int'(req_o[1]), 1);
    drain(1);

    // deferred config change
    put(0, 32'h600);
    split_i = 2'b00;
    tick; tick; tick;
    chk(dma_ok_o == 2'b11, "R9 change held while data", int'(dma_ok_o), 3);
    take(0);
    tick; tick;
    chk(dma_ok_o == 2'b01, "R1 split 00 dma_ok", int'(dma_ok_o), 1);
    msz = '{16, 0};

    // zero share channel
    put(1, 32'h700);
    chk(empty_o[1] == 1'b1 && req_o[1] == 1'b0, "R3 write to zero share", int'(empty_o[1]), 1);
    for (int i = 0; i < 7; i++) put(0, 32'h800 + i);
    chk(req_o[0] == 1'b0, "R2 16 share below 8", int'(req_o[0]), 0);
    put(0, 32'h807);
    chk(req_o[0] == 1'b1, "R2 16 share 1/2", int'(req_o[0]), 1);
    for (int i = 8; i < 16; i++) put(0, 32'h800 + i);
    chk(full_o[0] == 1'b1, "R1 ch0 full at 16", int'(full_o[0]), 1);
    put(0, 32'hbeef);
    drain(0);

    // end of sector flush
    thr0_i = 2'b00; eos_flush_en_i[0] = 1'b1;
    tick; tick;
    for (int i = 0; i < 126; i++) begin put(0, 32'h1000 + i); take(0); end
    put(0, 32'h2000);
    chk(req_o[0] == 1'b0, "R8 no req at word 127", int'(req_o[0]), 0);
    take(0);
    put(0, 32'h2001);
    chk(req_o[0] == 1'b1, "R8 sector end flush", int'(req_o[0]), 1);
    take(0);
    chk(req_o[0] == 1'b0, "R8 req clears", int'(req_o[0]), 0);
    eos_flush_en_i[0] = 1'b0;

    // split 11
    split_i = 2'b11; tick; tick;
    chk(dma_ok_o == 2'b10, "R1 split 11 dma_ok", int'(dma_ok_o), 2);

    // defaults
    cfg_sel_i = 1'b0; chan_en_i = 2'b01; tick; tick;
    chk(dma_ok_o == 2'b01, "R4 only ch0 enabled", int'(dma_ok_o), 1);
    msz = '{16, 0};
    for (int i = 0; i < 11; i++) put(0, 32'h3000 + i);
    chk(req_o[0] == 1'b0, "R4 below 3/4 of 16", int'(req_o[0]), 0);
    put(0, 32'h300b);
    chk(req_o[0] == 1'b1, "R4 3/4 of 16", int'(req_o[0]), 1);
    drain(0);
    chan_en_i = 2'b10; tick; tick;
    chk(dma_ok_o == 2'b10, "R4 only ch1 enabled", int'(dma_ok_o), 2);
    chan_en_i = 2'b11; tick; tick;
    chk(dma_ok_o == 2'b11, "R4 both enabled even", int'(dma_ok_o), 3);
    msz = '{8, 8};
    for (int i = 0; i < 5; i++) put(1, 32'h4000 + i);
    chk(req_o[1] == 1'b0, "R4 even below 6", int'(req_o[1]), 0);
    put(1, 32'h4005);
    chk(req_o[1] == 1'b1, "R4 even 3/4 of 8", int'(req_o[1]), 1);
    drain(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule